// File: doc/BRIEF.md
# Command Ring Producer with Tail Doorbell

This block fills a circular ring of fixed-size command slots. Each slot holds one 64-byte command. Commands arrive on a valid/ready input. Each accepted command goes to the slot that the producer's tail index names, and the write leaves through a plain registered write port. The tail then steps forward and wraps back to slot 0 after the last slot.

Placing a command does not make it visible to the consumer. Publication is a separate step: a 32-bit doorbell write carries the new tail index. Any number of placed commands can be published by one doorbell write. The doorbell fires in two cases: an explicit flush request while entries are waiting, or the waiting count reaching a configured batch size. The consumer reports its head position on a separate update input. The producer compares that head with its own tail, so it never overwrites a slot the consumer has not read. One slot always stays empty, which lets a full ring be told apart from an empty one.

Top module: `cmd_ring_producer`

## Requirements
- R1: After reset:
  - tail and head are both slot 0;
  - `cmd_ready` is 1;
  - `mem_we` and `db_we` are 0;
  - `db_data` is 0.
- R2: A command accepted at a clock edge (`cmd_valid` and `cmd_ready` both 1) appears on the write port in the next cycle:
  - `mem_we` is 1;
  - `mem_addr` is the tail index from before the edge;
  - `mem_wdata` is the command.

  The tail then advances by one. In a cycle after an edge with no acceptance, `mem_we` is 0.
- R3: The tail index after slot DEPTH-1 is slot 0, including for a DEPTH that is not a power of two.
- R4: `cmd_ready` is 0 exactly when (tail+1) mod DEPTH equals the head, so at most DEPTH-1 slots are occupied.
- R5: `cmd_valid` while `cmd_ready` is 0 is ignored: no write port pulse, and the tail does not move.
- R6: The waiting count is the number of accepted but unpublished commands, including one accepted at the current edge. When it reaches BATCH_MAX:
  - `db_we` pulses for one cycle after that edge;
  - the count returns to zero.
- R7: A flush at an edge where the waiting count is nonzero, including a command accepted at that same edge, causes a one-cycle `db_we` pulse in the next cycle and clears the count.
- R8: A flush at an edge where the waiting count is zero produces no doorbell write.
- R9: During a doorbell pulse, `db_data` is the tail index after every command accepted up to that edge, zero-extended to 32 bits. The doorbell pulse is never earlier than the write port pulse of the last command it publishes.
- R10: When `head_upd_valid` is 1 at an edge, the head takes `head_upd_idx`, and `cmd_ready` reflects the new head in the next cycle. A head update and a command acceptance at the same edge are both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Ring has a free slot |
| cmd_data | input | ENTRY_W | Command contents (64 bytes by default) |
| flush | input | 1 | Publish all waiting commands |
| head_upd_valid | input | 1 | Consumer head report is valid |
| head_upd_idx | input | $clog2(DEPTH) | Consumer's consumed position |
| mem_we | output | 1 | Ring memory write enable |
| mem_addr | output | $clog2(DEPTH) | Ring slot written |
| mem_wdata | output | ENTRY_W | Command written to the slot |
| db_we | output | 1 | Tail doorbell write strobe |
| db_data | output | DB_W | New tail index written to the doorbell |

## Verification
Several functions can fall in the same cycle, and the bench provokes each overlap on purpose.

- **Acceptance with a flush or threshold:** an acceptance can complete a batch while a flush is also asserted. This must give exactly one doorbell pulse carrying the tail that includes the new command.
- **Acceptance with a head report:** an acceptance and a consumer head report can share an edge. Both must take effect, and the ready flag must follow the new head one cycle later.

The bench forces these overlaps at the full boundary of a five-slot ring with a batch size of three. It then runs a long random sweep of valid, flush and head updates, and judges every cycle against an arithmetic model of tail, head and waiting count.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  // Reason a doorbell write is issued in a given cycle.
  typedef enum logic [1:0] {
    DB_NONE  = 2'd0,
    DB_BATCH = 2'd1,
    DB_FLUSH = 2'd2
  } db_cause_e;
endpackage

// File: rtl/cmd_ring_track.sv
// Tail and head index registers plus the full test.
module cmd_ring_track #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             head_upd_valid,
  input  logic [IDX_W-1:0] head_upd_idx,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] tail_nxt,
  output logic             ready
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] head;
  logic [IDX_W-1:0] tail_inc;

  always_comb begin
    tail_inc = (tail == LAST) ? '0 : tail + 1'b1;
    ready    = (tail_inc != head);
    tail_nxt = accept ? tail_inc : tail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tail <= '0;
      head <= '0;
    end else begin
      tail <= tail_nxt;
      if (head_upd_valid) head <= head_upd_idx;
    end
  end
endmodule

// File: rtl/cmd_ring_publish.sv
// Counts placed-but-unpublished entries and issues the tail doorbell.
module cmd_ring_publish
  import cmd_ring_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int BATCH_MAX = 4,
  parameter int DB_W      = 32,
  parameter int IDX_W     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             flush,
  input  logic [IDX_W-1:0] tail_nxt,
  output logic             db_we,
  output logic [DB_W-1:0]  db_data
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] BATCH_LIM = CNT_W'(BATCH_MAX);

  logic [CNT_W-1:0] pend;
  logic [CNT_W-1:0] pend_nxt;
  db_cause_e        cause;

  always_comb begin
    pend_nxt = pend + CNT_W'(accept);
    if (pend_nxt >= BATCH_LIM)
      cause = DB_BATCH;
    else if (flush && (pend_nxt != '0))
      cause = DB_FLUSH;
    else
      cause = DB_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      db_we   <= 1'b0;
      db_data <= '0;
    end else begin
      db_we <= (cause != DB_NONE);
      if (cause != DB_NONE) begin
        db_data <= DB_W'(tail_nxt);
        pend    <= '0;
      end else begin
        pend    <= pend_nxt;
      end
    end
  end
endmodule

// File: rtl/cmd_ring_wport.sv
// Registered write port toward the ring memory.
module cmd_ring_wport #(
  parameter int ENTRY_W = 512,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [IDX_W-1:0]   slot,
  input  logic [ENTRY_W-1:0] cmd,
  output logic               mem_we,
  output logic [IDX_W-1:0]   mem_addr,
  output logic [ENTRY_W-1:0] mem_wdata
);
  always_ff @(posedge clk) begin
    if (rst) mem_we <= 1'b0;
    else     mem_we <= accept;
  end

  // Address and data are not reset; they only matter with mem_we.
  always_ff @(posedge clk) begin
    if (accept) begin
      mem_addr  <= slot;
      mem_wdata <= cmd;
    end
  end
endmodule

// File: rtl/cmd_ring_producer.sv
module cmd_ring_producer #(
  parameter int DEPTH     = 16,
  parameter int ENTRY_W   = 512,
  parameter int BATCH_MAX = 4,
  parameter int DB_W      = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [ENTRY_W-1:0]       cmd_data,
  input  logic                     flush,
  input  logic                     head_upd_valid,
  input  logic [$clog2(DEPTH)-1:0] head_upd_idx,
  output logic                     mem_we,
  output logic [$clog2(DEPTH)-1:0] mem_addr,
  output logic [ENTRY_W-1:0]       mem_wdata,
  output logic                     db_we,
  output logic [DB_W-1:0]          db_data
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             accept;
  logic [IDX_W-1:0] tail;
  logic [IDX_W-1:0] tail_nxt;
  logic             ready;

  assign cmd_ready = ready;
  assign accept    = cmd_valid & ready;

  cmd_ring_track #(.DEPTH(DEPTH), .IDX_W(IDX_W)) track_i (
    .clk(clk), .rst(rst), .accept(accept),
    .head_upd_valid(head_upd_valid), .head_upd_idx(head_upd_idx),
    .tail(tail), .tail_nxt(tail_nxt), .ready(ready)
  );

  cmd_ring_wport #(.ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) wport_i (
    .clk(clk), .rst(rst), .accept(accept), .slot(tail), .cmd(cmd_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  cmd_ring_publish #(.DEPTH(DEPTH), .BATCH_MAX(BATCH_MAX), .DB_W(DB_W),
                     .IDX_W(IDX_W)) publish_i (
    .clk(clk), .rst(rst), .accept(accept), .flush(flush),
    .tail_nxt(tail_nxt), .db_we(db_we), .db_data(db_data)
  );
endmodule

// File: rtl/cmd_ring_producer_chk.sv
module cmd_ring_producer_chk #(
  parameter int DEPTH     = 16,
  parameter int BATCH_MAX = 4,
  parameter int DB_W      = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cmd_valid,
  input logic                     cmd_ready,
  input logic                     mem_we,
  input logic [$clog2(DEPTH)-1:0] mem_addr,
  input logic                     db_we,
  input logic [DB_W-1:0]          db_data
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] exp_addr;
  logic [CNT_W-1:0] since_db;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_addr <= '0;
      since_db <= '0;
    end else begin
      if (mem_we)
        exp_addr <= (mem_addr == IDX_W'(DEPTH - 1)) ? '0 : mem_addr + 1'b1;
      if (db_we)       since_db <= '0;
      else if (mem_we) since_db <= since_db + 1'b1;
    end
  end

  // R2: slots are written in strict ring order
  assert_slot_order_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_addr == exp_addr);

  // R3: written slot stays inside the ring
  assert_addr_range_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> 32'(mem_addr) < DEPTH);

  // R5: an offer while the ring is full causes no write
  assert_no_write_full_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> !mem_we);

  // R2: an accepted offer is written next cycle
  assert_accept_writes_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> mem_we);

  // R6: unpublished writes never pile up to the batch limit
  assert_batch_bound_R6: assert property (@(posedge clk) disable iff (rst)
    32'(since_db) < BATCH_MAX);

  // R9: doorbell carries a valid slot index
  assert_db_range_R9: assert property (@(posedge clk) disable iff (rst)
    db_we |-> db_data < DB_W'(DEPTH));
endmodule

bind cmd_ring_producer cmd_ring_producer_chk #(
  .DEPTH(DEPTH), .BATCH_MAX(BATCH_MAX), .DB_W(DB_W)
) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .db_we(db_we), .db_data(db_data)
);

// File: tb/cmd_ring_producer_tb_top.sv
`timescale 1ns/1ps
module cmd_ring_producer_tb_top;
  localparam int D  = 5;
  localparam int B  = 3;
  localparam int W  = 64;
  localparam int IW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [W-1:0]  cmd_data = '0;
  logic          flush = 1'b0;
  logic          head_upd_valid = 1'b0;
  logic [IW-1:0] head_upd_idx = '0;
  logic          mem_we;
  logic [IW-1:0] mem_addr;
  logic [W-1:0]  mem_wdata;
  logic          db_we;
  logic [31:0]   db_data;

  int n_chk  = 0;
  int n_fail = 0;
  int mt = 0, mh = 0, pend = 0;
  bit last_hv = 0;

  always #5 clk = ~clk;

  cmd_ring_producer #(.DEPTH(D), .ENTRY_W(W), .BATCH_MAX(B), .DB_W(32)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .flush(flush), .head_upd_valid(head_upd_valid),
    .head_upd_idx(head_upd_idx), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .db_we(db_we), .db_data(db_data)
  );

  task automatic check(input bit ok, input string tag,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic step(input bit v, input logic [W-1:0] d, input bit f,
                      input bit hv, input int hidx);
    bit exp_rdy, acc, fire;
    int old, pn;
    string tag;
    cmd_valid = v; cmd_data = d; flush = f;
    head_upd_valid = hv; head_upd_idx = IW'(hidx);
    exp_rdy = (((mt + 1) % D) != mh);
    check(cmd_ready === exp_rdy, last_hv ? "R10" : "R4", cmd_ready, exp_rdy);
    acc = v && exp_rdy;
    old = mt;
    @(posedge clk);
    @(negedge clk);
    check(mem_we === acc, (v && !exp_rdy) ? "R5" : "R2", mem_we, acc);
    if (acc) begin
      check(mem_addr == IW'(old), (old == D - 1) ? "R3" : "R2", mem_addr, old);
      check(mem_wdata == d, "R2", mem_wdata, d);
      mt = (mt + 1) % D;
    end
    pn = pend + (acc ? 1 : 0);
    fire = (pn >= B) || (f && pn != 0);
    if (pn >= B)    tag = "R6";
    else if (f)     tag = (pn != 0) ? "R7" : "R8";
    else            tag = "R6";
    check(db_we === fire, tag, db_we, fire);
    if (fire) check(db_data == 32'(mt), "R9", db_data, mt);
    pend = fire ? 0 : pn;
    if (hv) mh = hidx;
    last_hv = hv;
    cmd_valid = 0; flush = 0; head_upd_valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(cmd_ready === 1'b1, "R1", cmd_ready, 1);
    check(mem_we === 1'b0, "R1", mem_we, 0);
    check(db_we === 1'b0, "R1", db_we, 0);
    check(db_data == 32'd0, "R1", db_data, 0);

    // R6: batch of three publishes by threshold
    for (int i = 0; i < 3; i++) step(1, 64'h100 + 64'(i), 0, 0, 0);
    // fill the last free slot (R4), then offer while full (R5)
    step(1, 64'h200, 0, 0, 0);
    check(cmd_ready === 1'b0, "R4", cmd_ready, 0);
    step(1, 64'h201, 0, 0, 0);
    // R7: flush publishes the single waiting entry; R8: second flush idle
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    // R10: head update in a full cycle with a blocked offer
    step(1, 64'h300, 0, 1, 2);
    // R10 + R3: acceptance and head update on the same edge, wrapping tail
    step(1, 64'h301, 0, 1, 3);
    // R7/R6 overlap: flush on the edge that completes a batch
    step(1, 64'h302, 0, 0, 0);
    step(1, 64'h303, 1, 0, 0);
    // flush with a same-edge acceptance as the only waiting entry (R7)
    step(0, 0, 0, 1, 1);
    step(1, 64'h304, 1, 0, 0);

    // Random sweep over valid, flush and consumer progress
    for (int k = 0; k < 3000; k++) begin
      int occ, hidx;
      bit v, f, hv;
      v  = ($urandom % 4) != 0;
      f  = ($urandom % 6) == 0;
      hv = ($urandom % 3) == 0;
      occ  = (mt - mh + D) % D;
      hidx = (mh + int'($urandom % (occ + 1))) % D;
      step(v, {$urandom, $urandom}, f, hv, hidx);
    end
    finish_run();
  end
endmodule